// File: doc/BRIEF.md
# ADC Start-Up Initialization Sequencer

This block sits between the decimation path of a stereo ADC and its digital output. Each channel has a power-up control bit. When either bit goes from 0 to 1, the block runs a settling interval. The interval is counted in sample-rate strobes, and its length comes from a fixed set chosen by a 2-bit high-pass filter mode. For the whole interval both output channels are held at two's-complement zero. After the interval the raw converted samples reach the outputs, one cycle late, together with their valid flag.

The filter mode is captured when the interval starts, so the interval already running is not changed by later writes to it. Mode 11 is not a legal configuration. It raises an error flag and keeps the outputs at zero. Dropping both power-up bits returns the sequencer to idle at once. A new 0→1 transition on either bit restarts the interval at full length.

Top module: `adc_init_seq`

## Requirements
- R1: A 0→1 change on either power-up input, with a legal filter mode, sets `busy_o` in the cycle after the clock edge that samples it.
- R2: The interval counts `fs_tick_i` pulses that arrive while busy. Mode 00 counts LEN_00 pulses (3088 by default), mode 01 counts LEN_01 (1552) and mode 10 counts LEN_10 (784). `busy_o` falls after the edge that samples the last counted pulse.
- R3: The filter mode is captured on the start transition. A change to `hpf_mode_i` during the interval has no effect on its length.
- R4: A start transition with mode 11 raises `mode_err_o` and keeps `busy_o` low. The outputs stay at zero until both power-up bits drop or a new start transition arrives with a legal mode. `busy_o` and `mode_err_o` are never high together.
- R5: While idle, initializing or in error, `out_l_o` and `out_r_o` are zero. The outputs are registered, so they follow the internal state one cycle late.
- R6: Once the interval has completed and at least one power-up bit stays high, `out_l_o` and `out_r_o` equal `raw_l_i` and `raw_r_i` one cycle late. In every state, `out_vld_o` equals `raw_vld_i` one cycle late.
- R7: When both power-up bits are 0, the next cycle shows `busy_o` and `mode_err_o` low, and the outputs are zero.
- R8: A start transition while initializing, passing samples or in error restarts the interval at full length, using the mode sampled at that transition.
- R9: While `rst_ni` is low, `busy_o`, `mode_err_o`, `out_vld_o` and both output samples are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_l_i | input | 1 | Left channel power-up bit |
| pwr_r_i | input | 1 | Right channel power-up bit |
| hpf_mode_i | input | 2 | High-pass filter mode; selects interval length (11 illegal) |
| fs_tick_i | input | 1 | One-cycle strobe per sample period |
| raw_vld_i | input | 1 | Raw sample valid |
| raw_l_i | input | DATA_W | Left raw sample, two's complement |
| raw_r_i | input | DATA_W | Right raw sample, two's complement |
| out_vld_o | output | 1 | Output sample valid |
| out_l_o | output | DATA_W | Left output sample |
| out_r_o | output | DATA_W | Right output sample |
| busy_o | output | 1 | Initialization interval in progress |
| mode_err_o | output | 1 | Illegal filter mode captured at start |

## Verification
The bench sweeps every legal mode against each power-up source and several strobe spacings. For every combination it compares the number of strobes counted while busy with the interval length for that mode. A design that counted one strobe too many or too few, or counted clock cycles instead of strobes, would fail here.

It also changes the mode in the middle of an interval, to catch a design that decodes the live mode instead of the captured one. It starts a second channel during the interval and again after it, to catch a design that ignores the restart or resumes the old count. It selects the illegal mode and checks that the outputs stay at zero with no busy flag, and it aborts in the middle of a count. Every cycle, the registered outputs are compared against zero or against the previous cycle's raw sample. This catches a pass path that opens early or late by a cycle.

// File: rtl/adc_init_pkg.sv
package adc_init_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_INIT  = 2'd1,
    ST_RUN   = 2'd2,
    ST_FAULT = 2'd3
  } seq_state_e;

  localparam logic [1:0] HPF_ILLEGAL = 2'b11;
  localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/adc_init_detect.sv
module adc_init_detect #(
  parameter int unsigned NCH = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] pwr_i,
  output logic           start_o,
  output logic           any_on_o
);
  logic [NCH-1:0] prev_q;
  logic [NCH-1:0] rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= pwr_i;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_rise
    assign rise[g] = pwr_i[g] & ~prev_q[g];
  end

  assign start_o  = |rise;
  assign any_on_o = |pwr_i;
endmodule

// File: rtl/adc_init_len.sv
module adc_init_len #(
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned LEN_00 = 3088,
  parameter int unsigned LEN_01 = 1552,
  parameter int unsigned LEN_10 = 784
) (
  input  logic [1:0]       mode_i,
  output logic [CNT_W-1:0] last_o,
  output logic             bad_o
);
  import adc_init_pkg::*;

  always_comb begin
    bad_o  = 1'b0;
    last_o = '0;
    unique case (mode_i)
      2'b00:   last_o = CNT_W'(LEN_00 - 1);
      2'b01:   last_o = CNT_W'(LEN_01 - 1);
      2'b10:   last_o = CNT_W'(LEN_10 - 1);
      default: bad_o  = 1'b1;
    endcase
  end
endmodule

// File: rtl/adc_init_fsm.sv
module adc_init_fsm #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             any_on_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] last_i,
  input  logic             bad_i,
  output logic             busy_o,
  output logic             err_o,
  output logic             pass_o
);
  import adc_init_pkg::*;

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      last_q  <= '0;
    end else if (!any_on_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (start_i) begin
      // capture limit once; later mode writes do not reach the count
      cnt_q   <= '0;
      last_q  <= last_i;
      state_q <= bad_i ? ST_FAULT : ST_INIT;
    end else if (state_q == ST_INIT && tick_i) begin
      if (cnt_q == last_q) begin
        state_q <= ST_RUN;
        cnt_q   <= '0;
      end else begin
        cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o = (state_q == ST_INIT);
  assign err_o  = (state_q == ST_FAULT);
  assign pass_o = (state_q == ST_RUN);
endmodule

// File: rtl/adc_init_gate.sv
module adc_init_gate #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pass_i,
  input  logic [DATA_W-1:0] raw_i,
  output logic [DATA_W-1:0] out_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     out_o <= '0;
    else if (pass_i) out_o <= raw_i;
    else             out_o <= '0;
  end
endmodule

// File: rtl/adc_init_seq.sv
module adc_init_seq #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LEN_00 = 3088,
  parameter int unsigned LEN_01 = 1552,
  parameter int unsigned LEN_10 = 784
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_l_i,
  input  logic              pwr_r_i,
  input  logic [1:0]        hpf_mode_i,
  input  logic              fs_tick_i,
  input  logic              raw_vld_i,
  input  logic [DATA_W-1:0] raw_l_i,
  input  logic [DATA_W-1:0] raw_r_i,
  output logic              out_vld_o,
  output logic [DATA_W-1:0] out_l_o,
  output logic [DATA_W-1:0] out_r_o,
  output logic              busy_o,
  output logic              mode_err_o
);
  import adc_init_pkg::*;

  localparam int unsigned LEN_A   = (LEN_00 > LEN_01) ? LEN_00 : LEN_01;
  localparam int unsigned LEN_MAX = (LEN_A > LEN_10) ? LEN_A : LEN_10;
  localparam int unsigned CNT_W   = (LEN_MAX < 2) ? 1 : $clog2(LEN_MAX);

  logic             start;
  logic             any_on;
  logic [CNT_W-1:0] last;
  logic             bad;
  logic             pass;
  logic [NUM_CH-1:0]             pwr_vec;
  logic [NUM_CH-1:0][DATA_W-1:0] raw_vec;
  logic [NUM_CH-1:0][DATA_W-1:0] out_vec;

  assign pwr_vec = {pwr_r_i, pwr_l_i};
  assign raw_vec = {raw_r_i, raw_l_i};

  adc_init_detect #(.NCH(NUM_CH)) i_detect (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pwr_i    (pwr_vec),
    .start_o  (start),
    .any_on_o (any_on)
  );

  adc_init_len #(
    .CNT_W  (CNT_W),
    .LEN_00 (LEN_00),
    .LEN_01 (LEN_01),
    .LEN_10 (LEN_10)
  ) i_len (
    .mode_i (hpf_mode_i),
    .last_o (last),
    .bad_o  (bad)
  );

  adc_init_fsm #(.CNT_W(CNT_W)) i_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .any_on_i (any_on),
    .tick_i   (fs_tick_i),
    .last_i   (last),
    .bad_i    (bad),
    .busy_o   (busy_o),
    .err_o    (mode_err_o),
    .pass_o   (pass)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    adc_init_gate #(.DATA_W(DATA_W)) i_gate (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pass_i (pass),
      .raw_i  (raw_vec[c]),
      .out_o  (out_vec[c])
    );
  end

  assign out_l_o = out_vec[0];
  assign out_r_o = out_vec[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_vld_o <= 1'b0;
    else         out_vld_o <= raw_vld_i;
  end
endmodule

// File: rtl/adc_init_seq_chk.sv
module adc_init_seq_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pwr_l_i,
  input logic              pwr_r_i,
  input logic [1:0]        hpf_mode_i,
  input logic              fs_tick_i,
  input logic              raw_vld_i,
  input logic              out_vld_o,
  input logic [DATA_W-1:0] out_l_o,
  input logic [DATA_W-1:0] out_r_o,
  input logic              busy_o,
  input logic              mode_err_o
);
  // R1
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pwr_l_i) || $rose(pwr_r_i)) && hpf_mode_i != 2'b11 |=> busy_o);

  // R2
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(fs_tick_i) || mode_err_o
                      || (!$past(pwr_l_i) && !$past(pwr_r_i)));

  // R4
  bad_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pwr_l_i) || $rose(pwr_r_i)) && hpf_mode_i == 2'b11 |=> mode_err_o && !busy_o);

  // R4
  excl_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({busy_o, mode_err_o}) <= 1);

  // R5
  init_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o || mode_err_o) |=> out_l_o == '0 && out_r_o == '0);

  // R6
  vld_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> out_vld_o == $past(raw_vld_i));

  // R7
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwr_l_i && !pwr_r_i) |=> !busy_o && !mode_err_o);

  // R7
  abort_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwr_l_i && !pwr_r_i) |=> ##1 out_l_o == '0 && out_r_o == '0);
endmodule

bind adc_init_seq adc_init_seq_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pwr_l_i    (pwr_l_i),
  .pwr_r_i    (pwr_r_i),
  .hpf_mode_i (hpf_mode_i),
  .fs_tick_i  (fs_tick_i),
  .raw_vld_i  (raw_vld_i),
  .out_vld_o  (out_vld_o),
  .out_l_o    (out_l_o),
  .out_r_o    (out_r_o),
  .busy_o     (busy_o),
  .mode_err_o (mode_err_o)
);

// File: tb/test_adc_init_seq.sv
module test_adc_init_seq;
  localparam int W  = 8;
  localparam int L0 = 12;
  localparam int L1 = 6;
  localparam int L2 = 3;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         pwr_l_i = 1'b0;
  logic         pwr_r_i = 1'b0;
  logic [1:0]   hpf_mode_i = 2'b00;
  logic         fs_tick_i = 1'b0;
  logic         raw_vld_i = 1'b0;
  logic [W-1:0] raw_l_i = '0;
  logic [W-1:0] raw_r_i = '0;
  logic         out_vld_o;
  logic [W-1:0] out_l_o;
  logic [W-1:0] out_r_o;
  logic         busy_o;
  logic         mode_err_o;

  int checks = 0;
  int errors = 0;
  int seed = 0;
  logic run_exp = 1'b0;
  logic done = 1'b0;

  adc_init_seq #(.DATA_W(W), .LEN_00(L0), .LEN_01(L1), .LEN_10(L2)) i_adc_init_seq (
    .clk_i, .rst_ni, .pwr_l_i, .pwr_r_i, .hpf_mode_i, .fs_tick_i, .raw_vld_i,
    .raw_l_i, .raw_r_i, .out_vld_o, .out_l_o, .out_r_o, .busy_o, .mode_err_o
  );

  always #4 clk_i = ~clk_i;

  function automatic int exp_len(input int m);
    return (m == 0) ? L0 : (m == 1) ? L1 : L2;
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one cycle: called at a falling edge, returns at the next falling edge
  task automatic cyc(input logic tick);
    logic pass_b, busy_b, ev;
    logic [W-1:0] el, er;
    seed++;
    raw_l_i   = W'(seed * 37 + 5);
    raw_r_i   = ~W'(seed * 11);
    raw_vld_i = (seed % 3) != 0;
    fs_tick_i = tick;
    pass_b = run_exp;
    busy_b = busy_o;
    el = pass_b ? raw_l_i : '0;
    er = pass_b ? raw_r_i : '0;
    ev = raw_vld_i;
    @(posedge clk_i);
    @(negedge clk_i);
    fs_tick_i = 1'b0;
    if (pass_b) begin
      chk(out_l_o == el, "R6 left pass", int'(out_l_o), int'(el));
      chk(out_r_o == er, "R6 right pass", int'(out_r_o), int'(er));
    end else begin
      chk(out_l_o == el, "R5 left zero", int'(out_l_o), int'(el));
      chk(out_r_o == er, "R5 right zero", int'(out_r_o), int'(er));
    end
    chk(out_vld_o == ev, "R6 valid delay", int'(out_vld_o), int'(ev));
    run_exp = (pwr_l_i | pwr_r_i) & ~busy_o & ~mode_err_o & (run_exp | busy_b);
  endtask

  task automatic count_ticks(input int sp, output int n);
    int k = 0;
    logic t;
    n = 0;
    while (busy_o && k < 2000) begin
      t = ((k % sp) == sp - 1);
      if (t) n++;
      cyc(t);
      k++;
    end
  endtask

  task automatic go_idle();
    pwr_l_i = 1'b0;
    pwr_r_i = 1'b0;
    cyc(1'b0);
    chk(!busy_o && !mode_err_o, "R7 idle flags", int'({busy_o, mode_err_o}), 0);
    cyc(1'b1);
  endtask

  initial begin
    int n;
    #2;
    chk(busy_o == 0 && mode_err_o == 0 && out_vld_o == 0 && out_l_o == 0 && out_r_o == 0,
        "R9 reset state", int'({busy_o, mode_err_o, out_vld_o, out_l_o, out_r_o}), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    cyc(1'b1);
    chk(!busy_o, "R9 idle after reset", int'(busy_o), 0);

    // sweep: mode x source x strobe spacing
    for (int m = 0; m < 3; m++) begin
      for (int src = 1; src < 4; src++) begin
        for (int sp = 1; sp < 4; sp++) begin
          go_idle();
          hpf_mode_i = 2'(m);
          pwr_l_i = src[0];
          pwr_r_i = src[1];
          cyc(1'b1);
          chk(busy_o == 1'b1, "R1 busy on start", int'(busy_o), 1);
          count_ticks(sp, n);
          chk(n == exp_len(m), "R2 interval length", n, exp_len(m));
          chk(!busy_o && !mode_err_o, "R2 done flags", int'({busy_o, mode_err_o}), 0);
          for (int i = 0; i < 4; i++) cyc(i[0]);
        end
      end
    end

    // R3: mode change during count has no effect
    go_idle();
    hpf_mode_i = 2'b10;
    pwr_l_i = 1'b1;
    cyc(1'b0);
    hpf_mode_i = 2'b00;
    count_ticks(1, n);
    chk(n == L2, "R3 captured mode", n, L2);

    // R8: second channel start after completion restarts full length
    hpf_mode_i = 2'b01;
    cyc(1'b1);
    pwr_r_i = 1'b1;
    cyc(1'b1);
    chk(busy_o == 1'b1, "R8 restart from run", int'(busy_o), 1);
    count_ticks(2, n);
    chk(n == L1, "R8 restart length", n, L1);

    // R8: restart during interval
    go_idle();
    hpf_mode_i = 2'b00;
    pwr_l_i = 1'b1;
    cyc(1'b0);
    repeat (5) cyc(1'b1);
    hpf_mode_i = 2'b10;
    pwr_r_i = 1'b1;
    cyc(1'b1);
    count_ticks(1, n);
    chk(n == L2, "R8 restart mid interval", n, L2);

    // R7: abort mid interval, outputs stay zero, then fresh start
    go_idle();
    hpf_mode_i = 2'b00;
    pwr_r_i = 1'b1;
    cyc(1'b0);
    repeat (4) cyc(1'b1);
    pwr_r_i = 1'b0;
    cyc(1'b1);
    chk(!busy_o, "R7 abort mid interval", int'(busy_o), 0);
    repeat (3) cyc(1'b1);
    pwr_r_i = 1'b1;
    cyc(1'b0);
    count_ticks(1, n);
    chk(n == L0, "R7 full count after abort", n, L0);

    // R4: illegal mode
    go_idle();
    hpf_mode_i = 2'b11;
    pwr_l_i = 1'b1;
    cyc(1'b0);
    for (int i = 0; i < 20; i++) begin
      cyc(1'b1);
      chk(mode_err_o && !busy_o, "R4 fault held", int'({mode_err_o, busy_o}), 2);
    end
    hpf_mode_i = 2'b01;
    pwr_r_i = 1'b1;
    cyc(1'b0);
    chk(busy_o && !mode_err_o, "R4 leave fault by start", int'({mode_err_o, busy_o}), 1);
    count_ticks(1, n);
    chk(n == L1, "R8 length after fault", n, L1);
    hpf_mode_i = 2'b11;
    pwr_l_i = 1'b0;
    cyc(1'b0);
    pwr_l_i = 1'b1;
    cyc(1'b0);
    chk(mode_err_o, "R8 restart into fault", int'(mode_err_o), 1);
    pwr_l_i = 1'b0;
    pwr_r_i = 1'b0;
    cyc(1'b0);
    chk(!mode_err_o, "R7 abort clears fault", int'(mode_err_o), 0);
    repeat (3) cyc(1'b1);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule